// File: doc/BRIEF.md
# Multiplexed Bus Cycle Sequencer

This block is the bus master side of a minimum-mode multiplexed address/data bus. A client hands it one memory or I/O read or write at a time: a byte or a 16-bit word at a 20-bit byte address. The sequencer turns each request into bus cycles of the form T1, T2, T3, zero or more wait states (TW) and T4. The address goes out on the shared lines during T1, with a one-clock latch strobe. After T1 the sequencer produces the read or write strobe, the transceiver direction and enable, the memory/IO select and the active-low upper-byte enable. For reads it captures the returned data. A word at an odd address is split into two single-byte cycles.

A peripheral stretches a cycle by holding the ready input low. Another master can take the bus by raising the hold input. The request is granted only between bus cycles, never between the two halves of a split word. While the bus is granted, every bus driver and control line is released. Only the latch strobe stays driven. With no request pending, the sequencer idles and drives no strobes.

Top module: `mbus_cycle_seq`

## Requirements
- R1: During and directly after reset, ale is 0, rd_n, wr_n, den_n and bhe_n are 1, hlda and ad_oe are 0, ctl_oe is 1, and req_ready is 1 when hold_in is low.
- R2: A request is accepted on a rising edge where req_valid and req_ready are both high, and T1 starts on that edge. In T1, ale is high for exactly one clock, ad_out carries address bits 15:0, a_hi carries bits 19:16, and ad_oe is 1. Every bus cycle lasts at least four clocks.
- R3: In a read, rd_n is low in T2, T3 and every wait state and high in T4. dt_r is 0 and ad_oe is 0 from T2 on. ad_in is captured on the edge that ends the last T3/TW. done_valid is high during the final T4 with the assembled data on rsp_rdata: a byte returns in bits 7:0 with bits 15:8 zero, and a word returns with its low-address byte in bits 7:0.
- R4: In a write, wr_n is low from the start of T2 through the wait states, and dt_r is 1. From T2 until the middle of T4 the data is on ad_out with ad_oe high. A byte at an even address goes on bits 7:0 and a byte at an odd address goes on bits 15:8. The unused lane is 0.
- R5: den_n is low from the middle of T2 to the middle of T4. It is high in the first half of T2 and in the second half of T4.
- R6: bhe_n is low in T1 exactly when the cycle uses bits 15:8. That is the case for an odd byte and for an even word. It is high for an even byte. Together with address bit 0, this selects the low byte (0 with bhe_n 1), the high byte (1 with bhe_n 0) or the word (0 with bhe_n 0).
- R7: A word at an even address takes one bus cycle. A word at an odd address A takes two: first A with the low data byte on bits 15:8, then A+1 (with carry into the upper address bits) with the high data byte on bits 7:0.
- R8: ready_in is sampled on the edge ending T3 and each wait state. Each low sample adds one wait state, so the strobe is low for 2+W clocks with W wait states.
- R9: m_io is 1 for memory and 0 for I/O. It holds the cycle's value from T1 through T4.
- R10: If hold_in is high on the rising edge that ends T4 or an idle clock, hlda is 1 from the next clock on. This has priority over a pending request. While hlda is 1, ctl_oe and ad_oe are 0 and no T1 starts.
- R11: If hold_in is low on a rising edge while hlda is 1, hlda is 0 after that edge, and a pending request then starts normally.
- R12: If hold_in rises during the first half of a split word, it is not granted until the second cycle's T4 has finished.
- R13: With no request pending, rd_n and wr_n stay high, ale stays low, and req_ready is high whenever hold_in is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Transfer request present |
| req_ready | output | 1 | Sequencer can take a request on this edge |
| req_write | input | 1 | 1 = write, 0 = read |
| req_mem | input | 1 | 1 = memory space, 0 = I/O space |
| req_word | input | 1 | 1 = 16-bit transfer, 0 = byte |
| req_addr | input | 20 | Byte address |
| req_wdata | input | 16 | Write data, byte transfers use bits 7:0 |
| done_valid | output | 1 | High in the final T4 of a transfer |
| rsp_rdata | output | 16 | Read data, valid with done_valid on reads |
| ready_in | input | 1 | Slave ready, low inserts wait states |
| hold_in | input | 1 | Bus request from another master |
| hlda | output | 1 | Bus granted to the other master |
| ad_in | input | 16 | Data returned on the shared lines |
| ad_out | output | 16 | Address (T1) or write data on the shared lines |
| ad_oe | output | 1 | Drive enable for ad_out |
| a_hi | output | 4 | Upper address bits during T1 |
| ale | output | 1 | Address latch strobe, high in T1 |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| dt_r | output | 1 | Transceiver direction, 1 = transmit |
| den_n | output | 1 | Transceiver enable, active low |
| m_io | output | 1 | 1 = memory cycle, 0 = I/O cycle |
| bhe_n | output | 1 | Upper byte lane enable, active low in T1 |
| ctl_oe | output | 1 | Drive enable for the control strobes |

## Verification
Two events can land on the same rising edge. The first is a hold request reaching the T4 boundary while the next transfer is already waiting. The bench raises hold_in in T2 of a cycle that has two wait states and queues a second request behind it. It then requires hlda to appear exactly six clocks after the latch strobe, with no further T1 in between. The second is a hold request arriving inside the first half of an odd-address word. There the grant must wait until the second half's T4, which the bench judges by the count of latch strobes and the position of the grant within the second cycle.

// File: rtl/mbus_pkg.sv
// Shared types for the multiplexed bus cycle sequencer.
// Assumes a bus built from T-states that advance one per clock.
package mbus_pkg;
    typedef enum logic [2:0] {
        S_IDLE = 3'd0,
        S_T1   = 3'd1,
        S_T2   = 3'd2,
        S_T3   = 3'd3,
        S_TW   = 3'd4,
        S_T4   = 3'd5,
        S_HOLD = 3'd6
    } tstate_e;

    // True in the states where the strobes are active.
    function automatic logic is_data_phase(tstate_e s);
        return (s == S_T2) || (s == S_T3) || (s == S_TW);
    endfunction
endpackage

// File: rtl/mbus_fsm.sv
// T-state sequencer. Decides when to start a cycle, insert waits or grant
// the bus. Assumes hold_in is already synchronised to clk.
module mbus_fsm
    import mbus_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    req_valid,
    input  logic    split_pend,
    input  logic    hold_in,
    input  logic    ready_in,
    output tstate_e state,
    output logic    open_slot
);
    tstate_e nxt;
    logic    boundary;

    assign boundary  = (state == S_IDLE) || (state == S_T4);
    assign open_slot = boundary && !split_pend && !hold_in;

    // Next-state selection; hold wins over a new request at a boundary.
    always_comb begin
        nxt = state;
        case (state)
            S_IDLE:  nxt = hold_in ? S_HOLD : (req_valid ? S_T1 : S_IDLE);
            S_T1:    nxt = S_T2;
            S_T2:    nxt = S_T3;
            S_T3:    nxt = ready_in ? S_T4 : S_TW;
            S_TW:    nxt = ready_in ? S_T4 : S_TW;
            S_T4:    nxt = split_pend ? S_T1 :
                           (hold_in ? S_HOLD : (req_valid ? S_T1 : S_IDLE));
            S_HOLD:  nxt = hold_in ? S_HOLD : S_IDLE;
            default: nxt = S_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end
endmodule

// File: rtl/mbus_cmd.sv
// Command holder. Latches the accepted request, splits odd-address words
// into two beats, places write bytes on lanes and assembles read data.
// Assumes DW is two bytes wide.
module mbus_cmd
    import mbus_pkg::*;
#(
    parameter int AW = 20,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  tstate_e       state,
    input  logic          accept,
    input  logic          req_write,
    input  logic          req_mem,
    input  logic          req_word,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    input  logic          ready_in,
    input  logic [DW-1:0] ad_in,
    output logic [AW-1:0] beat_addr,
    output logic          c_write,
    output logic          c_mem,
    output logic          upper_en,
    output logic [DW-1:0] lane_wdata,
    output logic          split_pend,
    output logic          done_valid,
    output logic [DW-1:0] rdata
);
    localparam int LW = DW / 2;

    logic [AW-1:0] c_addr;
    logic [DW-1:0] c_wdata;
    logic          c_word, second, a0, last_sample;
    logic [LW-1:0] byte_sel;

    assign beat_addr   = second ? c_addr + AW'(1) : c_addr;
    assign a0          = beat_addr[0];
    assign split_pend  = c_word && c_addr[0] && !second;
    assign upper_en    = a0 || (c_word && !c_addr[0]);
    assign byte_sel    = second ? c_wdata[DW-1:LW] : c_wdata[LW-1:0];
    assign last_sample = ((state == S_T3) || (state == S_TW)) && ready_in;

    // Lane placement of write data for the current beat.
    always_comb begin
        if (c_word && !c_addr[0]) lane_wdata = c_wdata;
        else if (a0)              lane_wdata = {byte_sel, {LW{1'b0}}};
        else                      lane_wdata = {{LW{1'b0}}, byte_sel};
    end

    // Request latch and split-beat tracking.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_addr  <= '0;
            c_wdata <= '0;
            c_write <= 1'b0;
            c_mem   <= 1'b0;
            c_word  <= 1'b0;
            second  <= 1'b0;
        end else if (accept) begin
            c_addr  <= req_addr;
            c_wdata <= req_wdata;
            c_write <= req_write;
            c_mem   <= req_mem;
            c_word  <= req_word;
            second  <= 1'b0;
        end else if (state == S_T4 && split_pend) begin
            second  <= 1'b1;
        end
    end

    // Read data assembly and completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata      <= '0;
            done_valid <= 1'b0;
        end else begin
            done_valid <= last_sample && !split_pend;
            if (last_sample && !c_write) begin
                if (second) begin
                    rdata[DW-1:LW] <= ad_in[LW-1:0];
                end else begin
                    rdata[LW-1:0]  <= a0 ? ad_in[DW-1:LW] : ad_in[LW-1:0];
                    rdata[DW-1:LW] <= (c_word && !a0) ? ad_in[DW-1:LW] : '0;
                end
            end
        end
    end
endmodule

// File: rtl/mbus_pins.sv
// Pin decoder. Derives the bus strobes from the T-state. A falling-edge
// flop provides the half-cycle edges of the transceiver enable and the
// write-data release. Assumes AW > DW.
module mbus_pins
    import mbus_pkg::*;
#(
    parameter int AW = 20,
    parameter int DW = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  tstate_e          state,
    input  logic [AW-1:0]    beat_addr,
    input  logic             c_write,
    input  logic             c_mem,
    input  logic             upper_en,
    input  logic [DW-1:0]    lane_wdata,
    output logic [DW-1:0]    ad_out,
    output logic             ad_oe,
    output logic [AW-DW-1:0] a_hi,
    output logic             ale,
    output logic             rd_n,
    output logic             wr_n,
    output logic             dt_r,
    output logic             den_n,
    output logic             m_io,
    output logic             bhe_n,
    output logic             ctl_oe,
    output logic             hlda
);
    logic mid_q, dphase, in_t1, in_t4;

    assign dphase = is_data_phase(state);
    assign in_t1  = (state == S_T1);
    assign in_t4  = (state == S_T4);

    // Mid-cycle marker: set mid-T2, cleared mid-T4.
    always_ff @(negedge clk) begin
        if (!rst_n) mid_q <= 1'b0;
        else        mid_q <= dphase;
    end

    assign ale    = in_t1;
    assign ad_oe  = in_t1 || (c_write && (dphase || (in_t4 && mid_q)));
    assign a_hi   = in_t1 ? beat_addr[AW-1:DW] : '0;
    assign rd_n   = !(dphase && !c_write);
    assign wr_n   = !(dphase && c_write);
    assign den_n  = !mid_q;
    assign dt_r   = c_write;
    assign m_io   = c_mem;
    assign bhe_n  = !(in_t1 && upper_en);
    assign hlda   = (state == S_HOLD);
    assign ctl_oe = !hlda;

    // Shared-line mux: address in T1, write data while driven.
    always_comb begin
        if (in_t1)      ad_out = beat_addr[DW-1:0];
        else if (ad_oe) ad_out = lane_wdata;
        else            ad_out = '0;
    end
endmodule

// File: rtl/mbus_cycle_seq.sv
// Top of the multiplexed bus cycle sequencer. Connects the T-state FSM, the
// command holder and the pin decoder. Takes one request at a time.
module mbus_cycle_seq
    import mbus_pkg::*;
#(
    parameter int AW = 20,
    parameter int DW = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic             req_write,
    input  logic             req_mem,
    input  logic             req_word,
    input  logic [AW-1:0]    req_addr,
    input  logic [DW-1:0]    req_wdata,
    output logic             done_valid,
    output logic [DW-1:0]    rsp_rdata,
    input  logic             ready_in,
    input  logic             hold_in,
    output logic             hlda,
    input  logic [DW-1:0]    ad_in,
    output logic [DW-1:0]    ad_out,
    output logic             ad_oe,
    output logic [AW-DW-1:0] a_hi,
    output logic             ale,
    output logic             rd_n,
    output logic             wr_n,
    output logic             dt_r,
    output logic             den_n,
    output logic             m_io,
    output logic             bhe_n,
    output logic             ctl_oe
);
    tstate_e       state;
    logic          open_slot, accept, split_pend;
    logic          c_write, c_mem, upper_en;
    logic [AW-1:0] beat_addr;
    logic [DW-1:0] lane_wdata;

    assign req_ready = open_slot;
    assign accept    = open_slot && req_valid;

    mbus_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .split_pend (split_pend),
        .hold_in    (hold_in),
        .ready_in   (ready_in),
        .state      (state),
        .open_slot  (open_slot)
    );

    mbus_cmd #(.AW(AW), .DW(DW)) u_cmd (
        .clk        (clk),
        .rst_n      (rst_n),
        .state      (state),
        .accept     (accept),
        .req_write  (req_write),
        .req_mem    (req_mem),
        .req_word   (req_word),
        .req_addr   (req_addr),
        .req_wdata  (req_wdata),
        .ready_in   (ready_in),
        .ad_in      (ad_in),
        .beat_addr  (beat_addr),
        .c_write    (c_write),
        .c_mem      (c_mem),
        .upper_en   (upper_en),
        .lane_wdata (lane_wdata),
        .split_pend (split_pend),
        .done_valid (done_valid),
        .rdata      (rsp_rdata)
    );

    mbus_pins #(.AW(AW), .DW(DW)) u_pins (
        .clk        (clk),
        .rst_n      (rst_n),
        .state      (state),
        .beat_addr  (beat_addr),
        .c_write    (c_write),
        .c_mem      (c_mem),
        .upper_en   (upper_en),
        .lane_wdata (lane_wdata),
        .ad_out     (ad_out),
        .ad_oe      (ad_oe),
        .a_hi       (a_hi),
        .ale        (ale),
        .rd_n       (rd_n),
        .wr_n       (wr_n),
        .dt_r       (dt_r),
        .den_n      (den_n),
        .m_io       (m_io),
        .bhe_n      (bhe_n),
        .ctl_oe     (ctl_oe),
        .hlda       (hlda)
    );
endmodule

// File: rtl/mbus_seq_chk.sv
// Checker for the bus cycle sequencer. Watches only the top-level ports and
// is attached with the bind statement below.
module mbus_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic ale,
    input logic rd_n,
    input logic wr_n,
    input logic hlda,
    input logic hold_in,
    input logic ctl_oe,
    input logic ad_oe,
    input logic m_io,
    input logic req_ready
);
    a_r2_ale_single: assert property (@(posedge clk) disable iff (!rst_n)
        ale |=> !ale);

    a_r3_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(!rd_n && !wr_n));

    a_r9_mio_stable: assert property (@(posedge clk) disable iff (!rst_n)
        ale |=> $stable(m_io));

    a_r10_float: assert property (@(posedge clk) disable iff (!rst_n)
        hlda |-> (!ctl_oe && !ad_oe && !ale));

    a_r10_keep: assert property (@(posedge clk) disable iff (!rst_n)
        (hlda && hold_in) |=> hlda);

    a_r11_release: assert property (@(posedge clk) disable iff (!rst_n)
        (hlda && !hold_in) |=> !hlda);

    a_r13_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (rd_n && wr_n && !ale));
endmodule

bind mbus_cycle_seq mbus_seq_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ale       (ale),
    .rd_n      (rd_n),
    .wr_n      (wr_n),
    .hlda      (hlda),
    .hold_in   (hold_in),
    .ctl_oe    (ctl_oe),
    .ad_oe     (ad_oe),
    .m_io      (m_io),
    .req_ready (req_ready)
);

// File: tb/mbus_cycle_seq_test.sv
`timescale 1ns/1ps
module mbus_cycle_seq_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0, req_mem = 1'b0, req_word = 1'b0;
    logic [19:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic        ready_in = 1'b1, hold_in = 1'b0;
    logic [15:0] ad_in = '0;
    logic        req_ready, done_valid, hlda, ad_oe, ale, rd_n, wr_n;
    logic        dt_r, den_n, m_io, bhe_n, ctl_oe;
    logic [15:0] rsp_rdata, ad_out;
    logic [3:0]  a_hi;

    always #2.5 clk = ~clk;

    mbus_cycle_seq uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_mem(req_mem), .req_word(req_word),
        .req_addr(req_addr), .req_wdata(req_wdata), .done_valid(done_valid),
        .rsp_rdata(rsp_rdata), .ready_in(ready_in), .hold_in(hold_in),
        .hlda(hlda), .ad_in(ad_in), .ad_out(ad_out), .ad_oe(ad_oe),
        .a_hi(a_hi), .ale(ale), .rd_n(rd_n), .wr_n(wr_n), .dt_r(dt_r),
        .den_n(den_n), .m_io(m_io), .bhe_n(bhe_n), .ctl_oe(ctl_oe)
    );

    typedef struct {
        logic [19:0] addr;
        logic        bhe_n;
        logic        wr;
        logic        mem;
        logic [15:0] data;
        int          waits;
    } beat_t;
    typedef struct {
        logic        wr;
        logic [15:0] rdata;
    } res_t;

    beat_t beat_q[$];
    res_t  res_q[$];
    beat_t cur;
    int    checks = 0, fails = 0, ale_cnt = 0, k = 0, scnt = 0;
    bit    active = 1'b0, finished = 1'b0;

    function automatic logic [7:0] mem_byte(input logic [19:0] a);
        return a[7:0] ^ {a[19:16], a[11:8]} ^ 8'hA5;
    endfunction

    task automatic chk(input string rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    // Driver: queue the expected beats and result, then hand the request over.
    task automatic issue(input bit wr, input bit mem, input bit word,
                         input logic [19:0] a, input logic [15:0] wd, input int w);
        beat_t b;
        res_t  r;
        bit    acc;
        b.wr = wr; b.mem = mem; b.waits = w; b.addr = a;
        if (word && a[0]) begin
            b.bhe_n = 1'b0; b.data = {wd[7:0], 8'h00}; beat_q.push_back(b);
            b.addr = a + 20'd1; b.bhe_n = 1'b1; b.data = {8'h00, wd[15:8]};
            beat_q.push_back(b);
        end else if (word) begin
            b.bhe_n = 1'b0; b.data = wd; beat_q.push_back(b);
        end else begin
            b.bhe_n = !a[0];
            b.data  = a[0] ? {wd[7:0], 8'h00} : {8'h00, wd[7:0]};
            beat_q.push_back(b);
        end
        r.wr = wr;
        r.rdata = word ? {mem_byte(a + 20'd1), mem_byte(a)} : {8'h00, mem_byte(a)};
        res_q.push_back(r);
        @(posedge clk); #1;
        req_valid = 1'b1; req_write = wr; req_mem = mem; req_word = word;
        req_addr = a; req_wdata = wd;
        do begin
            @(negedge clk);
            acc = req_ready;
            @(posedge clk);
        end while (!acc);
        #1 req_valid = 1'b0;
    endtask

    task automatic drain();
        while (beat_q.size() != 0 || res_q.size() != 0 || req_valid) @(posedge clk);
        repeat (3) @(posedge clk);
    endtask

    // Monitor and slave model, sampled just after each rising edge.
    initial begin
        res_t r;
        forever begin
            @(posedge clk); #1;
            if (rst_n) begin
                if (ale) begin
                    ale_cnt++;
                    if (beat_q.size() == 0) begin
                        chk("R2", "unexpected ale", 1, 0);
                        active = 1'b0;
                    end else begin
                        cur = beat_q.pop_front();
                        active = 1'b1; k = 0; scnt = 0;
                        chk("R2", "T1 address low", ad_out, cur.addr[15:0]);
                        chk("R2", "T1 address high", a_hi, cur.addr[19:16]);
                        chk("R2", "T1 ad_oe", ad_oe, 1);
                        chk("R6", "bhe_n in T1", bhe_n, cur.bhe_n);
                        chk("R9", "m_io in T1", m_io, cur.mem);
                    end
                end else if (active) begin
                    k++;
                end
                if (active) begin
                    if (k >= 1 && k <= 2 + cur.waits)
                        scnt += (cur.wr ? !wr_n : !rd_n) ? 1 : 0;
                    if (k == 1) begin
                        chk(cur.wr ? "R4" : "R3", "dt_r in T2", dt_r, cur.wr);
                        chk("R5", "den_n early T2", den_n, 1);
                        chk("R2", "ale low in T2", ale, 0);
                        if (cur.wr) begin
                            chk("R4", "rd_n idle in write", rd_n, 1);
                            chk("R4", "write lane data", ad_out, cur.data);
                            chk("R4", "ad_oe in T2", ad_oe, 1);
                        end else begin
                            chk("R3", "wr_n idle in read", wr_n, 1);
                            chk("R3", "ad_oe off in read", ad_oe, 0);
                        end
                    end
                    if (k == 3 + cur.waits) begin
                        chk("R8", "strobe low clocks", scnt, 2 + cur.waits);
                        chk(cur.wr ? "R4" : "R3", "strobes high in T4", {rd_n, wr_n}, 2'b11);
                        chk("R5", "den_n early T4", den_n, 0);
                        chk("R9", "m_io in T4", m_io, cur.mem);
                        if (cur.wr) chk("R4", "data held early T4", ad_oe, 1);
                    end
                    ready_in = (k >= 2 + cur.waits);
                    ad_in = {mem_byte(cur.addr | 20'd1), mem_byte(cur.addr & ~20'd1)};
                end
                if (done_valid) begin
                    if (res_q.size() == 0) begin
                        chk("R3", "unexpected done", 1, 0);
                    end else begin
                        r = res_q.pop_front();
                        if (!r.wr) chk("R3", "read data", rsp_rdata, r.rdata);
                        else       chk("R4", "write done in T4", done_valid, 1);
                    end
                end
            end
        end
    end

    // Half-cycle monitor, sampled just after each falling edge.
    initial begin
        forever begin
            @(negedge clk); #1;
            if (rst_n && active) begin
                if (k == 1) chk("R5", "den_n late T2", den_n, 0);
                if (k == 3 + cur.waits) begin
                    chk("R5", "den_n late T4", den_n, 1);
                    if (cur.wr) chk("R4", "data released mid T4", ad_oe, 0);
                end
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL R13 watchdog expired actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int base, kk;
        repeat (3) @(posedge clk); #1;
        chk("R1", "ale in reset", ale, 0);
        chk("R1", "strobes in reset", {rd_n, wr_n, den_n, bhe_n}, 4'hF);
        chk("R1", "hlda/ad_oe in reset", {hlda, ad_oe}, 2'b00);
        chk("R1", "ctl_oe in reset", ctl_oe, 1);
        rst_n = 1'b1;
        @(posedge clk); #1;
        chk("R1", "req_ready after reset", req_ready, 1);

        issue(0, 1, 0, 20'h12344, 16'h0, 0);
        issue(0, 1, 0, 20'h12345, 16'h0, 0);
        issue(0, 1, 1, 20'hA0010, 16'h0, 0);
        issue(0, 1, 1, 20'h1FFFF, 16'h0, 1);   // R7 split across carry
        issue(1, 1, 0, 20'h00100, 16'h00C3, 0);
        issue(1, 0, 0, 20'h00201, 16'h0077, 2);
        issue(1, 1, 1, 20'h30000, 16'hBEEF, 0);
        issue(1, 1, 1, 20'h30003, 16'hCAFE, 3); // R7 split write
        issue(0, 0, 1, 20'h00061, 16'h0, 1);
        drain();

        for (int i = 0; i < 4; i++) begin
            @(posedge clk); #1;
            chk("R13", "idle quiet", {rd_n, wr_n, ale, req_ready}, 4'b1101);
        end

        // R10/R11 grant from idle.
        base = ale_cnt;
        @(posedge clk); #2 hold_in = 1'b1;
        chk("R10", "hlda before edge", hlda, 0);
        @(posedge clk); #2;
        chk("R10", "hlda after edge", hlda, 1);
        chk("R10", "bus floated", {ctl_oe, ad_oe}, 2'b00);
        fork issue(0, 1, 0, 20'h00400, 16'h0, 0); join_none
        repeat (5) @(posedge clk); #2;
        chk("R10", "no cycle while granted", ale_cnt, base);
        hold_in = 1'b0;
        @(posedge clk); #2;
        chk("R11", "hlda dropped", hlda, 0);
        drain();
        chk("R11", "pending request ran", ale_cnt, base + 1);

        // R10 hold meets a pending request at the T4 boundary.
        base = ale_cnt;
        issue(0, 1, 1, 20'h05000, 16'h0, 2);
        fork issue(1, 1, 0, 20'h05002, 16'h0011, 0); join_none
        @(posedge clk); #2 hold_in = 1'b1;
        kk = -1;
        for (int i = 0; i < 20; i++) begin
            @(posedge clk); #2;
            if (hlda) begin kk = k; break; end
        end
        chk("R10", "grant clock after ale", kk, 6);
        chk("R10", "hold beats pending request", ale_cnt, base + 1);
        repeat (3) @(posedge clk); #2 hold_in = 1'b0;
        drain();
        chk("R11", "request after release", ale_cnt, base + 2);

        // R12 hold during the first half of a split word.
        base = ale_cnt;
        issue(1, 1, 1, 20'h06011, 16'h1234, 0);
        @(posedge clk); #2 hold_in = 1'b1;
        kk = -1;
        for (int i = 0; i < 20; i++) begin
            @(posedge clk); #2;
            if (hlda) begin kk = k; break; end
        end
        chk("R12", "both halves before grant", ale_cnt, base + 2);
        chk("R12", "grant after second T4", kk, 4);
        repeat (2) @(posedge clk); #2 hold_in = 1'b0;
        drain();

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule